// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is an 8 KB data cache between one processor load/store port and a lower-level memory. It holds 32-byte lines in two ways of 128 sets. A request is looked up with two tag comparisons that run side by side, and a multiplexer picks the word from the way that hits. Each line carries a valid bit and a dirty bit. Each set carries one recency bit that names the way to replace next.

Stores change only the cached copy and mark the line dirty. A store miss first brings the line in and then writes it. When a miss must replace a dirty line, the whole line is written to memory before the new line is read. A clean victim is simply overwritten. The processor starts an access with a one-cycle strobe while the cache is ready, and gets a one-cycle completion pulse back. The memory side moves whole lines, one request at a time, with a request/acknowledge handshake.

Top module: `dcache_2way`

## Requirements
- R1: A 34-bit byte address `cpu_addr_i` is split as tag = bits [33:12], set index = bits [11:5], word select = bits [4:2]. Bits [1:0] are zero, because accesses are 32-bit words. The memory line address `mem_addr_o` is {tag, index}, 29 bits. Lines with equal tags in different sets are independent.
- R2: Reset (`rst_ni` low, asynchronous) clears every valid, dirty and recency bit. After reset `cpu_ready_o`=1, `cpu_done_o`=0 and `mem_req_o`=0, and any earlier contents are treated as absent.
- R3: A way hits only when its valid bit is set and its stored tag equals the request tag. At most one way hits. A load hit returns the addressed word and makes no memory request.
- R4: When neither way of a set is valid, the miss fills way 0. A second tag in the same set then fills way 1, and both lines stay resident.
- R5: On a miss with both ways valid, the victim is the least recently used way. The per-set bit is updated on every hit and on every refill so that it names the other way.
- R6: A store hit writes the word only into the cache, makes no memory request and sets the line dirty. A later load returns the stored value.
- R7: A dirty victim is written to memory as a whole line at its own address (`mem_we_o`=1) before the refill read. A clean victim causes no memory write.
- R8: A store miss reads the line from memory, then merges the stored word into it (write-allocate). A later load hits and returns the stored value.
- R9: `mem_req_o` stays high with stable `mem_addr_o` and `mem_we_o` until `mem_ack_i` is seen. `mem_rdata_i` is taken as the refill line in the acknowledge cycle.
- R10: `cpu_req_i` is accepted only in a cycle with `cpu_ready_o`=1, and is ignored otherwise. Each accepted access produces exactly one `cpu_done_o` pulse of one cycle. For loads, `cpu_rdata_o` carries the word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access strobe, one cycle |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 34 | Byte address, word aligned |
| cpu_wdata_i | input | 32 | Store data |
| cpu_ready_o | output | 1 | Cache idle, can take a strobe |
| cpu_done_o | output | 1 | Access complete pulse |
| cpu_rdata_o | output | 32 | Load data, valid with done |
| mem_req_o | output | 1 | Memory line request |
| mem_we_o | output | 1 | 1 = line write-back, 0 = refill read |
| mem_addr_o | output | 29 | Line address {tag, index} |
| mem_wdata_o | output | 256 | Victim line being written back |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 256 | Refill line, valid with ack |

## Verification
The assertions check on every cycle the properties that never depend on history: no more than one way hits, a memory request holds its address until acknowledged, a write-back occurs only for a valid dirty victim, a refilled line is valid and clean, a stored-into line is dirty, the recency bit names the other way after each update, and completion is a single-cycle pulse. Which way becomes the victim over a sequence of accesses, whether written-back data reaches memory intact, write-allocate merging, the loss of contents at reset, and a strobe dropped while busy show up only in the bench. Its scenarios do this by counting memory reads and writes per access and comparing load data against a flat model of memory.

// File: rtl/dc2_pkg.sv
package dc2_pkg;
  localparam int WAYS = 2;
  typedef enum logic [1:0] {ST_IDLE, ST_CMP, ST_WB, ST_FILL} st_e;
endpackage

// File: rtl/dc2_way.sv
module dc2_way #(
  parameter int IDX_W  = 7,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 256,
  parameter int WORD_W = 32,
  localparam int WSEL_W = $clog2(LINE_W / WORD_W),
  localparam int SETS   = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              wr_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [LINE_W-1:0] line_o
);
  logic [SETS-1:0]   valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (wr_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[idx_i]  <= fill_tag_i;
      data_q[idx_i] <= fill_line_i;
    end else if (wr_i) begin
      data_q[idx_i][wsel_i*WORD_W +: WORD_W] <= wdata_i;
    end
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign line_o  = data_q[idx_i];

  a_r7_fill_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)]);
  a_r6_store_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> dirty_q[$past(idx_i)]);
  a_r8_store_valid_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> valid_q[idx_i] && !fill_i);
endmodule

// File: rtl/dc2_lru.sv
module dc2_lru #(
  parameter int IDX_W = 7,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             upd_i,
  input  logic             used_way_i,
  output logic             victim_o
);
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lru_q <= '0;
    else if (upd_i) lru_q[idx_i] <= ~used_way_i;
  end

  assign victim_o = lru_q[idx_i];

  a_r5_lru_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> lru_q[$past(idx_i)] != $past(used_way_i));
endmodule

// File: rtl/dc2_ctrl.sv
module dc2_ctrl
  import dc2_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 7,
  parameter int WORD_W = 32,
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W  = 8 << OFF_W,
  localparam int WSEL_W  = $clog2(LINE_W / WORD_W),
  localparam int BYTE_W  = OFF_W - WSEL_W,
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cpu_req_i,
  input  logic                         cpu_we_i,
  input  logic [ADDR_W-1:0]            cpu_addr_i,
  input  logic [WORD_W-1:0]            cpu_wdata_i,
  output logic                         cpu_ready_o,
  output logic                         cpu_done_o,
  output logic [WORD_W-1:0]            cpu_rdata_o,
  input  logic [WAYS-1:0][TAG_W-1:0]   way_tag_i,
  input  logic [WAYS-1:0]              way_valid_i,
  input  logic [WAYS-1:0]              way_dirty_i,
  input  logic [WAYS-1:0][LINE_W-1:0]  way_line_i,
  input  logic                         lru_victim_i,
  output logic [IDX_W-1:0]             idx_o,
  output logic [WAYS-1:0]              fill_o,
  output logic [WAYS-1:0]              wr_o,
  output logic [TAG_W-1:0]             fill_tag_o,
  output logic [WSEL_W-1:0]            wsel_o,
  output logic [WORD_W-1:0]            wdata_o,
  output logic                         lru_upd_o,
  output logic                         lru_way_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [LADDR_W-1:0]           mem_addr_o,
  output logic [LINE_W-1:0]            mem_wdata_o,
  input  logic                         mem_ack_i
);
  st_e                       state_q;
  logic [ADDR_W-1:BYTE_W]    addr_q;
  logic                      we_q, victim_q, done_q;
  logic [WORD_W-1:0]         wdata_q, rdata_q;

  logic [TAG_W-1:0]  req_tag;
  logic [WAYS-1:0]   hit;
  logic              hit_any, hit_way, victim_c;
  logic [LINE_W-1:0] hit_line;

  assign req_tag = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_o   = addr_q[OFF_W +: IDX_W];
  assign wsel_o  = addr_q[BYTE_W +: WSEL_W];
  assign wdata_o = wdata_q;
  assign fill_tag_o = req_tag;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit[w]    = way_valid_i[w] && (way_tag_i[w] == req_tag);
    assign wr_o[w]   = (state_q == ST_CMP) && we_q && hit[w];
    assign fill_o[w] = (state_q == ST_FILL) && mem_ack_i && (victim_q == 1'(w));
  end

  assign hit_any  = |hit;
  assign hit_way  = hit[1];
  assign hit_line = way_line_i[hit_way];
  // fill an empty way before evicting, way 0 first
  assign victim_c = !way_valid_i[0] ? 1'b0 : (!way_valid_i[1] ? 1'b1 : lru_victim_i);

  assign lru_upd_o = ((state_q == ST_CMP) && hit_any) || ((state_q == ST_FILL) && mem_ack_i);
  assign lru_way_o = (state_q == ST_FILL) ? victim_q : hit_way;

  assign mem_req_o   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ? {way_tag_i[victim_q], idx_o} : {req_tag, idx_o};
  assign mem_wdata_o = way_line_i[victim_q];

  assign cpu_ready_o = (state_q == ST_IDLE);
  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      victim_q <= 1'b0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cpu_req_i) begin
          addr_q  <= cpu_addr_i[ADDR_W-1:BYTE_W];
          we_q    <= cpu_we_i;
          wdata_q <= cpu_wdata_i;
          state_q <= ST_CMP;
        end
        ST_CMP: if (hit_any) begin
          done_q  <= 1'b1;
          rdata_q <= hit_line[wsel_o*WORD_W +: WORD_W];
          state_q <= ST_IDLE;
        end else begin
          victim_q <= victim_c;
          state_q  <= (way_valid_i[victim_c] && way_dirty_i[victim_c]) ? ST_WB : ST_FILL;
        end
        ST_WB:   if (mem_ack_i) state_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) state_q <= ST_CMP;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_ready_o |-> cpu_addr_i[BYTE_W-1:0] == '0);
  a_r3_hit_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CMP |-> $onehot0(hit));
  a_r6_no_mem_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CMP && hit_any |=> !mem_req_o);
  a_r7_wb_only_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> way_valid_i[victim_q] && way_dirty_i[victim_q]);
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way
  import dc2_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 7,
  parameter int WORD_W = 32,
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W  = 8 << OFF_W,
  localparam int WSEL_W  = $clog2(LINE_W / WORD_W),
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic [WORD_W-1:0]  cpu_wdata_i,
  output logic               cpu_ready_o,
  output logic               cpu_done_o,
  output logic [WORD_W-1:0]  cpu_rdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [LADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0]  mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [LINE_W-1:0]  mem_rdata_i
);
  logic [WAYS-1:0][TAG_W-1:0]  way_tag;
  logic [WAYS-1:0]             way_valid, way_dirty;
  logic [WAYS-1:0][LINE_W-1:0] way_line;
  logic [WAYS-1:0]             fill, wr;
  logic [IDX_W-1:0]            idx;
  logic [TAG_W-1:0]            fill_tag;
  logic [WSEL_W-1:0]           wsel;
  logic [WORD_W-1:0]           wdata;
  logic                        lru_upd, lru_way, lru_victim;

  dc2_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_ready_o, .cpu_done_o, .cpu_rdata_o,
    .way_tag_i(way_tag), .way_valid_i(way_valid), .way_dirty_i(way_dirty),
    .way_line_i(way_line), .lru_victim_i(lru_victim),
    .idx_o(idx), .fill_o(fill), .wr_o(wr), .fill_tag_o(fill_tag),
    .wsel_o(wsel), .wdata_o(wdata), .lru_upd_o(lru_upd), .lru_way_o(lru_way),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    dc2_way #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
    ) u_way (
      .clk_i, .rst_ni,
      .idx_i(idx), .fill_i(fill[w]), .fill_tag_i(fill_tag), .fill_line_i(mem_rdata_i),
      .wr_i(wr[w]), .wsel_i(wsel), .wdata_i(wdata),
      .tag_o(way_tag[w]), .valid_o(way_valid[w]), .dirty_o(way_dirty[w]),
      .line_o(way_line[w])
    );
  end

  dc2_lru #(.IDX_W(IDX_W)) u_lru (
    .clk_i, .rst_ni,
    .idx_i(idx), .upd_i(lru_upd), .used_way_i(lru_way), .victim_o(lru_victim)
  );
endmodule

// File: tb/dcache_2way_tb.sv
module dcache_2way_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [33:0]  cpu_addr_i = '0;
  logic [31:0]  cpu_wdata_i = '0;
  logic         cpu_ready_o, cpu_done_o;
  logic [31:0]  cpu_rdata_o;
  logic         mem_req_o, mem_we_o;
  logic [28:0]  mem_addr_o;
  logic [255:0] mem_wdata_o;
  logic         mem_ack_i = 1'b0;
  logic [255:0] mem_rdata_i = '0;

  always #10 clk_i = ~clk_i;

  dcache_2way u_dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // memory model
  function automatic logic [255:0] line_pat(input logic [28:0] la);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = {la[23:0], 5'b0, 3'(w)} ^ 32'hA500_0000;
    return l;
  endfunction

  logic [28:0]  mt_addr [16];
  logic [255:0] mt_data [16];
  int mt_n = 0;
  int rd_cnt = 0, wr_cnt = 0, mem_err = 0, wait_cnt = 0;
  logic [28:0] last_wb = '0, start_addr = '0;
  logic busy = 1'b0;

  function automatic logic [255:0] mem_read(input logic [28:0] la);
    for (int i = 0; i < mt_n; i++) if (mt_addr[i] == la) return mt_data[i];
    return line_pat(la);
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      mem_ack_i <= 1'b0;
      busy = 1'b0;
    end else if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
      busy = 1'b0;
    end else if (mem_req_o) begin
      if (!busy) begin
        busy = 1'b1;
        start_addr = mem_addr_o;
        wait_cnt = 0;
      end else begin
        if (mem_addr_o != start_addr) mem_err++;
        wait_cnt++;
        if (wait_cnt == 2) begin
          mem_ack_i <= 1'b1;
          if (mem_we_o) begin
            int slot;
            wr_cnt++;
            last_wb = mem_addr_o;
            slot = mt_n;
            for (int i = 0; i < mt_n; i++) if (mt_addr[i] == mem_addr_o) slot = i;
            mt_addr[slot] = mem_addr_o;
            mt_data[slot] = mem_wdata_o;
            if (slot == mt_n) mt_n++;
          end else begin
            rd_cnt++;
            mem_rdata_i <= mem_read(mem_addr_o);
          end
        end
      end
    end
  end

  // golden flat word memory
  logic [31:0] gl_addr [64];
  logic [31:0] gl_data [64];
  int gl_n = 0;

  function automatic logic [31:0] gold_read(input logic [33:0] a);
    logic [255:0] l;
    for (int i = 0; i < gl_n; i++) if (gl_addr[i] == a[33:2]) return gl_data[i];
    l = line_pat(a[33:5]);
    return l[a[4:2]*32 +: 32];
  endfunction

  task automatic gold_write(input logic [33:0] a, input logic [31:0] d);
    for (int i = 0; i < gl_n; i++) if (gl_addr[i] == a[33:2]) begin gl_data[i] = d; return; end
    gl_addr[gl_n] = a[33:2];
    gl_data[gl_n] = d;
    gl_n++;
  endtask

  function automatic logic [33:0] mk_addr(input logic [21:0] t, input logic [6:0] s, input logic [2:0] w);
    return {t, s, w, 2'b00};
  endfunction

  task automatic do_op(input logic we, input logic [33:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int nrd, output int nwr);
    int r0, w0;
    bit seen;
    r0 = rd_cnt; w0 = wr_cnt; seen = 0; rd = '0;
    chk("R10 ready before strobe", 64'(cpu_ready_o), 64'd1);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk_i);
    cpu_req_i = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (cpu_done_o) begin seen = 1; break; end
      @(negedge clk_i);
    end
    chk("R10 done seen", 64'(seen), 64'd1);
    rd = cpu_rdata_o;
    @(negedge clk_i);
    chk("R10 done one cycle", 64'(cpu_done_o), 64'd0);
    nrd = rd_cnt - r0;
    nwr = wr_cnt - w0;
  endtask

  typedef struct packed {
    logic        we;
    logic [21:0] tag;
    logic [6:0]  idx;
    logic [2:0]  wsel;
    logic [31:0] wdata;
    logic [1:0]  nrd;
    logic [1:0]  nwr;
    logic [21:0] wbtag;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [21:0] T1 = 22'h000001, T2 = 22'h3FFFFF, T3 = 22'h155555;
  localparam logic [31:0] DX = 32'h1111_2222, DY = 32'h3333_4444;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, T1, 7'd3, 3'd0, 32'h0, 2'd1, 2'd0, 22'h0, 8'd4},  // R4 empty set fills way 0
    '{1'b0, T1, 7'd3, 3'd5, 32'h0, 2'd0, 2'd0, 22'h0, 8'd3},  // R3 load hit
    '{1'b0, T2, 7'd3, 3'd1, 32'h0, 2'd1, 2'd0, 22'h0, 8'd4},  // R4 fills way 1
    '{1'b0, T1, 7'd3, 3'd2, 32'h0, 2'd0, 2'd0, 22'h0, 8'd4},  // R4 way 0 kept
    '{1'b1, T1, 7'd3, 3'd3, DX,    2'd0, 2'd0, 22'h0, 8'd6},  // R6 store hit
    '{1'b0, T3, 7'd3, 3'd0, 32'h0, 2'd1, 2'd0, 22'h0, 8'd5},  // R5 LRU evicts clean T2
    '{1'b0, T1, 7'd3, 3'd3, 32'h0, 2'd0, 2'd0, 22'h0, 8'd6},  // R6 reads stored word
    '{1'b1, T2, 7'd3, 3'd4, DY,    2'd1, 2'd0, 22'h0, 8'd8},  // R8 store miss allocates
    '{1'b0, T2, 7'd3, 3'd4, 32'h0, 2'd0, 2'd0, 22'h0, 8'd8},  // R8 merged word hits
    '{1'b0, T3, 7'd3, 3'd1, 32'h0, 2'd1, 2'd1, T1,    8'd7},  // R7 dirty T1 written back
    '{1'b0, T1, 7'd3, 3'd3, 32'h0, 2'd1, 2'd1, T2,    8'd7},  // R7 dirty T2 out, T1 back
    '{1'b0, T2, 7'd3, 3'd4, 32'h0, 2'd1, 2'd0, 22'h0, 8'd7},  // R7 clean victim, data from memory
    '{1'b0, T1, 7'd5, 3'd0, 32'h0, 2'd1, 2'd0, 22'h0, 8'd1},  // R1 other set independent
    '{1'b0, T1, 7'd3, 3'd3, 32'h0, 2'd0, 2'd0, 22'h0, 8'd5}   // R5 T1 still resident
  };

  initial begin
    logic [31:0] rd;
    int nrd, nwr;
    logic [33:0] a;
    string tag;
    int dones;

    // R2 reset state
    repeat (3) @(negedge clk_i);
    chk("R2 ready in reset", 64'(cpu_ready_o), 64'd1);
    chk("R2 no mem req in reset", 64'(mem_req_o), 64'd0);
    chk("R2 no done in reset", 64'(cpu_done_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      a = mk_addr(VECS[v].tag, VECS[v].idx, VECS[v].wsel);
      tag = $sformatf("R%0d vec%0d", VECS[v].rq, v);
      do_op(VECS[v].we, a, VECS[v].wdata, rd, nrd, nwr);
      if (VECS[v].we) gold_write(a, VECS[v].wdata);
      else chk({tag, " rdata"}, 64'(rd), 64'(gold_read(a)));
      chk({tag, " mem reads"}, 64'(nrd), 64'(VECS[v].nrd));
      chk({tag, " mem writes"}, 64'(nwr), 64'(VECS[v].nwr));
      if (VECS[v].nwr != 0)
        chk({tag, " wb line addr"}, 64'(last_wb), 64'({VECS[v].wbtag, VECS[v].idx}));
    end

    // R10 strobe while busy is ignored
    a = mk_addr(T1, 7'd9, 3'd0);
    cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = a;
    @(negedge clk_i);
    cpu_req_i = 1'b0;
    for (int i = 0; i < 50 && !mem_req_o; i++) @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_wdata_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    cpu_req_i = 1'b0;
    dones = 0;
    for (int i = 0; i < 40; i++) begin
      if (cpu_done_o) dones++;
      @(negedge clk_i);
    end
    chk("R10 one done for busy strobe pair", 64'(dones), 64'd1);
    do_op(1'b0, a, 32'h0, rd, nrd, nwr);
    chk("R10 ignored store left word", 64'(rd), 64'(gold_read(a)));
    chk("R3 reload hits", 64'(nrd), 64'd0);

    chk("R9 mem addr stable while waiting", 64'(mem_err), 64'd0);

    // R2 reset discards contents
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R2 ready after reset", 64'(cpu_ready_o), 64'd1);
    chk("R2 mem idle after reset", 64'(mem_req_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    a = mk_addr(T1, 7'd3, 3'd3);
    do_op(1'b0, a, 32'h0, rd, nrd, nwr);
    chk("R2 former hit now misses", 64'(nrd), 64'd1);
    chk("R2 data after reset", 64'(rd), 64'(gold_read(a)));
    chk("R4 empty set no write-back", 64'(nwr), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule